// File: doc/BRIEF.md
# Packet Stream Generator with Fault Injection

This block produces a 16-bit word stream shaped like a packet-over-channel transmit path, intended as a stimulus source for checking a receiver. A packet command gives a destination port, a fault code, a payload length in bytes and a first payload byte. The block frames the packet: an opening payload control word that carries the port, a header data word that carries the length, the payload packed two bytes per word, and a closing idle control word that reports how the packet ended. Every control word carries a 4-bit diagonal parity over the data words sent since the previous control word.

The fault code selects one of ten variants. Some corrupt the parity or set an error flag in the header, some remove or change the start and end marks, and some add legal control words in the middle of the payload. A second command sends one caller-supplied control word with computed parity that can be inverted. Idle control words fill every cycle in which no command is running. A done pulse marks the last word of each command, and busy shows when new commands are refused.

Top module: `pkt_stream_gen`

## Requirements
- R1: While rst_n is low, tx_data, tx_ctl, tx_valid, done and busy are all 0; from the first rising edge with rst_n high, tx_valid is 1 in every cycle.
- R2: Any word sent while no command is running is the idle fill control word 0x000F with tx_ctl = 1.
- R3: A command is taken at a rising edge only when busy is 0; if pkt_start and cw_start are both high, the packet is taken and the raw word is dropped; strobes while busy have no effect. The first word of a taken command appears one fill word after the accepting edge.
- R4: Control word layout is bit 15 kind (1 payload, 0 idle), bits 14:13 end status, bit 12 start mark, bits 11:4 port, bits 3:0 parity. A clean packet is: payload control word with start mark 1 and the port; header data word {error flag in bit 15, length in bits 14:0}; payload words with the higher byte in bits 15:8, bytes counting up by one from the first-byte value modulo 256; closing idle control word with port field 0 and start mark 0.
- R5: Parity: a 16-bit sum is cleared after each control word; each word updates it as sum = rotate-left-by-1(sum) XOR word, a control word entering with bits 3:0 forced to 1111; its bits 3:0 are then the XOR of the four nibbles of the sum.
- R6: End status of the closing word is 10 when the length is even (including zero) and 11 when odd; for an odd length the low byte of the last payload word is 0x00. A length of zero sends no payload words.
- R7: Fault code 1 inverts the closing word's parity and sets the header error flag; fault code 9 inverts the closing word's parity and leaves the flag clear.
- R8: Fault code 2 clears the start mark of the opening word; fault code 3 writes end status 00 in the closing word.
- R9: With N payload words and N at least 2, fault code 4 adds a payload control word (port kept, start mark 0, end status 00) after payload word N/2 (rounded down); fault code 5 adds an idle control word 0x000F-form ahead of that payload control word. Both words carry their own parity and restart the sum.
- R10: Fault code 6 sets the start mark in the closing word with the normal end status; fault code 7 sets the start mark and writes end status 01 (abort).
- R11: Fault code 8 writes end status 01 in the closing word and sets the header error flag; fault codes 10 to 15 behave as code 0.
- R12: A raw command sends cw_word bits 15:4 as one control word with computed parity in bits 3:0, inverted when cw_inv is 1.
- R13: done is a one-cycle pulse high exactly while the last word of a command (closing word or raw word) is on tx_data, busy falls in that same cycle, and busy is high from the edge after acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_start | input | 1 | Packet command strobe |
| pkt_port | input | 8 | Destination port for the opening word |
| pkt_err | input | 4 | Fault code, 0 to 9 |
| pkt_len | input | 15 | Payload length in bytes |
| pkt_seed | input | 8 | First payload byte |
| cw_start | input | 1 | Raw control word strobe |
| cw_word | input | 16 | Raw control word; bits 3:0 are replaced |
| cw_inv | input | 1 | Invert parity of the raw word |
| busy | output | 1 | A command is running; strobes are refused |
| done | output | 1 | Last word of a command is on tx_data |
| tx_data | output | 16 | Stream word |
| tx_ctl | output | 1 | 1 when tx_data is a control word |
| tx_valid | output | 1 | Stream word is valid |

## Verification
Two pairs of events can share a cycle: the closing word with its done pulse can coincide with a new strobe, and the packet and raw strobes can be raised together. The bench arms the next command so that its strobe rises in exactly the cycle that done is observed, and checks that it is taken with a single fill word in between; it also raises both strobes at once and checks that only the packet appears and the raw word never does. Strobes raised while busy are judged the same way, by the stream carrying on unchanged.

// File: rtl/pkt_gen_pkg.sv
// Shared constants, state type and parity helpers for the packet
// stream generator. Assumes a fixed 16-bit stream word.
package pkt_gen_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;
    localparam int DIP_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_HDR,
        ST_PAY,
        ST_MID_IDLE,
        ST_MID_PCW,
        ST_CLOSE,
        ST_RAW
    } seq_st_e;

    localparam logic [CODE_W-1:0] CODE_CLEAN     = 4'd0;
    localparam logic [CODE_W-1:0] CODE_DIP_FLAG  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_NO_START  = 4'd2;
    localparam logic [CODE_W-1:0] CODE_NO_END    = 4'd3;
    localparam logic [CODE_W-1:0] CODE_MID_PCW   = 4'd4;
    localparam logic [CODE_W-1:0] CODE_MID_IDLE  = 4'd5;
    localparam logic [CODE_W-1:0] CODE_TAIL_SOP  = 4'd6;
    localparam logic [CODE_W-1:0] CODE_ABORT_SOP = 4'd7;
    localparam logic [CODE_W-1:0] CODE_ABORT     = 4'd8;
    localparam logic [CODE_W-1:0] CODE_DIP_ONLY  = 4'd9;

    localparam logic [1:0] END_NONE  = 2'b00;
    localparam logic [1:0] END_ABORT = 2'b01;
    localparam logic [1:0] END_TWO   = 2'b10;
    localparam logic [1:0] END_ONE   = 2'b11;

    // Rotate a sum word left by one position.
    function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

    // Fold a 16-bit sum into 4 parity bits by XOR of its nibbles.
    function automatic logic [DIP_W-1:0] fold4(input logic [WORD_W-1:0] v);
        return v[15:12] ^ v[11:8] ^ v[7:4] ^ v[3:0];
    endfunction

    // Assemble a control word with an empty parity field.
    function automatic logic [WORD_W-1:0] ctl_word(input logic kind,
                                                   input logic [1:0] endst,
                                                   input logic start,
                                                   input logic [ADDR_W-1:0] addr);
        return {kind, endst, start, addr, 4'h0};
    endfunction

endpackage

// File: rtl/pkt_dip4_unit.sv
// Parity unit: keeps the diagonal running sum over data words and
// writes the folded parity into every control word passing through.
// Assumes exactly one word passes per clock.
module pkt_dip4_unit
    import pkt_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              is_ctl,
    input  logic              inv,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] sum_nx;
    logic [WORD_W-1:0] fed;

    // Combine the running sum with the word now being sent.
    always_comb begin
        fed      = is_ctl ? {word_in[WORD_W-1:DIP_W], 4'hF} : word_in;
        sum_nx   = rotl1(sum_q) ^ fed;
        word_out = is_ctl ? {word_in[WORD_W-1:DIP_W], fold4(sum_nx) ^ {DIP_W{inv}}}
                          : word_in;
    end

    // Hold the sum across data words; restart after a control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (is_ctl) sum_q <= '0;
        else             sum_q <= sum_nx;
    end

endmodule

// File: rtl/pkt_cmd_seq.sv
// Command sequencer: accepts packet and raw commands when idle, holds
// their fields and walks the framing states. Assumes fault codes above
// nine are to be handled as a clean packet.
module pkt_cmd_seq
    import pkt_gen_pkg::*;
#(
    parameter int LEN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic [ADDR_W-1:0] pkt_port,
    input  logic [CODE_W-1:0] pkt_err,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [BYTE_W-1:0] pkt_seed,
    input  logic              cw_start,
    input  logic [WORD_W-1:0] cw_word,
    input  logic              cw_inv,
    output seq_st_e           st,
    output logic [ADDR_W-1:0] port_q,
    output logic [CODE_W-1:0] code_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [BYTE_W-1:0] byte_q,
    output logic [WORD_W-1:0] raw_q,
    output logic              raw_inv_q,
    output logic              last_pay
);

    seq_st_e           st_nx;
    logic [LEN_W-1:0]  nw;
    logic [LEN_W-1:0]  half;
    logic [LEN_W-1:0]  pw;
    logic [LEN_W-1:0]  pw_inc;
    logic              mid_code;
    logic [BYTE_W-1:0] seed_q;
    logic              take_pkt;
    logic              take_raw;

    // Word counts derived from the held length.
    always_comb begin
        nw       = {1'b0, len_q[LEN_W-1:1]} + {{(LEN_W-1){1'b0}}, len_q[0]};
        half     = {1'b0, nw[LEN_W-1:1]};
        pw_inc   = pw + 1'b1;
        last_pay = (pw == nw - 1'b1);
        mid_code = (code_q == CODE_MID_PCW) || (code_q == CODE_MID_IDLE);
        take_pkt = (st == ST_IDLE) && pkt_start;
        take_raw = (st == ST_IDLE) && !pkt_start && cw_start;
    end

    // Next framing state.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:     if (pkt_start)     st_nx = ST_OPEN;
                         else if (cw_start) st_nx = ST_RAW;
            ST_OPEN:     st_nx = ST_HDR;
            ST_HDR:      st_nx = (nw == '0) ? ST_CLOSE : ST_PAY;
            ST_PAY:      if (last_pay)
                             st_nx = ST_CLOSE;
                         else if (mid_code && (pw_inc == half))
                             st_nx = (code_q == CODE_MID_IDLE) ? ST_MID_IDLE : ST_MID_PCW;
                         else
                             st_nx = ST_PAY;
            ST_MID_IDLE: st_nx = ST_MID_PCW;
            ST_MID_PCW:  st_nx = ST_PAY;
            ST_CLOSE:    st_nx = ST_IDLE;
            ST_RAW:      st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // State, command fields and payload counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            port_q    <= '0;
            code_q    <= CODE_CLEAN;
            len_q     <= '0;
            seed_q    <= '0;
            raw_q     <= '0;
            raw_inv_q <= 1'b0;
            pw        <= '0;
            byte_q    <= '0;
        end else begin
            st <= st_nx;
            if (take_pkt) begin
                port_q <= pkt_port;
                code_q <= (pkt_err > CODE_DIP_ONLY) ? CODE_CLEAN : pkt_err;
                len_q  <= pkt_len;
                seed_q <= pkt_seed;
            end
            if (take_raw) begin
                raw_q     <= cw_word;
                raw_inv_q <= cw_inv;
            end
            if (st == ST_HDR) begin
                pw     <= '0;
                byte_q <= seed_q;
            end else if (st == ST_PAY && !last_pay) begin
                pw     <= pw_inc;
                byte_q <= byte_q + 8'd2;
            end
        end
    end

endmodule

// File: rtl/pkt_word_fmt.sv
// Word formatter: builds the unprotected word for the current state,
// with the fault code applied. Assumes the parity field is filled in
// downstream for every control word.
module pkt_word_fmt
    import pkt_gen_pkg::*;
#(
    parameter int LEN_W = 15
) (
    input  seq_st_e           st,
    input  logic [ADDR_W-1:0] port_q,
    input  logic [CODE_W-1:0] code_q,
    input  logic [LEN_W-1:0]  len_q,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic [WORD_W-1:0] raw_q,
    input  logic              raw_inv_q,
    input  logic              last_pay,
    output logic [WORD_W-1:0] word,
    output logic              is_ctl,
    output logic              inv
);

    logic [1:0]        end_sel;
    logic              tail_start;
    logic              hdr_flag;
    logic [WORD_W-2:0] len_field;
    logic [BYTE_W-1:0] lo_byte;

    // Fault-dependent fields of the header and closing word.
    always_comb begin
        if (code_q == CODE_NO_END)
            end_sel = END_NONE;
        else if (code_q == CODE_ABORT || code_q == CODE_ABORT_SOP)
            end_sel = END_ABORT;
        else
            end_sel = len_q[0] ? END_ONE : END_TWO;
        tail_start = (code_q == CODE_TAIL_SOP) || (code_q == CODE_ABORT_SOP);
        hdr_flag   = (code_q == CODE_DIP_FLAG) || (code_q == CODE_ABORT);
        len_field  = '0;
        len_field[LEN_W-1:0] = len_q;
        lo_byte    = (last_pay && len_q[0]) ? '0 : byte_q + 1'b1;
    end

    // Select the word for the current state.
    always_comb begin
        word   = ctl_word(1'b0, END_NONE, 1'b0, '0);
        is_ctl = 1'b1;
        inv    = 1'b0;
        case (st)
            ST_OPEN:     word = ctl_word(1'b1, END_NONE, code_q != CODE_NO_START, port_q);
            ST_HDR: begin
                word   = {hdr_flag, len_field};
                is_ctl = 1'b0;
            end
            ST_PAY: begin
                word   = {byte_q, lo_byte};
                is_ctl = 1'b0;
            end
            ST_MID_IDLE: word = ctl_word(1'b0, END_NONE, 1'b0, '0);
            ST_MID_PCW:  word = ctl_word(1'b1, END_NONE, 1'b0, port_q);
            ST_CLOSE: begin
                word = ctl_word(1'b0, end_sel, tail_start, '0);
                inv  = (code_q == CODE_DIP_FLAG) || (code_q == CODE_DIP_ONLY);
            end
            ST_RAW: begin
                word = raw_q;
                inv  = raw_inv_q;
            end
            default: word = ctl_word(1'b0, END_NONE, 1'b0, '0);
        endcase
    end

endmodule

// File: rtl/pkt_stream_gen.sv
// Packet stream generator top: sequencer, formatter and parity unit,
// with registered stream outputs. Assumes one word per clock and a
// synchronous active-low reset.
module pkt_stream_gen
    import pkt_gen_pkg::*;
#(
    parameter int LEN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic [ADDR_W-1:0] pkt_port,
    input  logic [CODE_W-1:0] pkt_err,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [BYTE_W-1:0] pkt_seed,
    input  logic              cw_start,
    input  logic [WORD_W-1:0] cw_word,
    input  logic              cw_inv,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_ctl,
    output logic              tx_valid
);

    seq_st_e           st;
    logic [ADDR_W-1:0] port_q;
    logic [CODE_W-1:0] code_q;
    logic [LEN_W-1:0]  len_q;
    logic [BYTE_W-1:0] byte_q;
    logic [WORD_W-1:0] raw_q;
    logic              raw_inv_q;
    logic              last_pay;
    logic [WORD_W-1:0] fmt_word;
    logic              fmt_ctl;
    logic              fmt_inv;
    logic [WORD_W-1:0] prot_word;

    pkt_cmd_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_port  (pkt_port),
        .pkt_err   (pkt_err),
        .pkt_len   (pkt_len),
        .pkt_seed  (pkt_seed),
        .cw_start  (cw_start),
        .cw_word   (cw_word),
        .cw_inv    (cw_inv),
        .st        (st),
        .port_q    (port_q),
        .code_q    (code_q),
        .len_q     (len_q),
        .byte_q    (byte_q),
        .raw_q     (raw_q),
        .raw_inv_q (raw_inv_q),
        .last_pay  (last_pay)
    );

    pkt_word_fmt #(.LEN_W(LEN_W)) u_fmt (
        .st        (st),
        .port_q    (port_q),
        .code_q    (code_q),
        .len_q     (len_q),
        .byte_q    (byte_q),
        .raw_q     (raw_q),
        .raw_inv_q (raw_inv_q),
        .last_pay  (last_pay),
        .word      (fmt_word),
        .is_ctl    (fmt_ctl),
        .inv       (fmt_inv)
    );

    pkt_dip4_unit u_dip (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (fmt_word),
        .is_ctl   (fmt_ctl),
        .inv      (fmt_inv),
        .word_out (prot_word)
    );

    // Refuse commands whenever the sequencer is not idle.
    assign busy = (st != ST_IDLE);

    // Register the stream word and the end-of-command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_ctl   <= 1'b0;
            tx_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            tx_data  <= prot_word;
            tx_ctl   <= fmt_ctl;
            tx_valid <= 1'b1;
            done     <= (st == ST_CLOSE) || (st == ST_RAW);
        end
    end

endmodule

// File: rtl/pkt_stream_gen_chk.sv
// Property checker for the packet stream generator, bound to the top.
// Assumes the top's port names.
module pkt_stream_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] tx_data,
    input logic        tx_ctl,
    input logic        tx_valid
);

    logic armed;

    // Mark that at least one edge has passed outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_valid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> tx_valid);

    assert_fill_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!busy)) |-> (tx_ctl && tx_data == 16'h000F));

    assert_data_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !tx_ctl) |-> $past(busy));

    assert_done_on_ctl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_ctl && !busy));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(busy)) |-> done);

endmodule

bind pkt_stream_gen pkt_stream_gen_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .tx_data  (tx_data),
    .tx_ctl   (tx_ctl),
    .tx_valid (tx_valid)
);

// File: tb/test_pkt_stream_gen.sv
`timescale 1ns/1ps
module test_pkt_stream_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0;
    logic [7:0]  pkt_port = '0;
    logic [3:0]  pkt_err = '0;
    logic [14:0] pkt_len = '0;
    logic [7:0]  pkt_seed = '0;
    logic        cw_start = 1'b0;
    logic [15:0] cw_word = '0;
    logic        cw_inv = 1'b0;
    logic        busy, done, tx_ctl, tx_valid;
    logic [15:0] tx_data;

    always #2.5 clk = ~clk;

    pkt_stream_gen i_pkt_stream_gen (.*);

    typedef struct { logic [15:0] w; logic c; logic inv; logic dn; } raw_t;
    typedef struct { logic [15:0] d; logic c; logic dn; string tag; } ent_t;

    raw_t bq[$];
    ent_t exp_q[$];
    int n_cmp = 0, n_bad = 0;
    bit live = 0, saw_done = 0, accepted = 0, finished = 0;

    // command fields used by the next strobe
    logic [7:0] g_port; logic [3:0] g_code; logic [14:0] g_len; logic [7:0] g_seed;
    logic [15:0] g_cw; logic g_inv; string g_tag;

    function automatic logic [3:0] m_par(input logic [15:0] s);
        logic [3:0] r = 4'h0;
        for (int k = 0; k < 4; k++) r = r ^ s[k*4 +: 4];
        return r;
    endfunction

    function automatic logic [15:0] m_rot(input logic [15:0] s);
        return (s << 1) | (s >> 15);
    endfunction

    task automatic addw(input logic [15:0] w, input logic c, input logic inv, input logic dn);
        raw_t r; r.w = w; r.c = c; r.inv = inv; r.dn = dn; bq.push_back(r);
    endtask

    // Turn the built word list into expected stream entries.
    task automatic finalize(input string tag);
        logic [15:0] s = '0, p; ent_t e;
        e.d = 16'h000F; e.c = 1; e.dn = 0; e.tag = "R2"; exp_q.push_back(e);
        foreach (bq[i]) begin
            if (bq[i].c) begin
                p = m_rot(s) ^ {bq[i].w[15:4], 4'hF};
                e.d = {bq[i].w[15:4], m_par(p) ^ {4{bq[i].inv}}};
                s = '0;
            end else begin
                s = m_rot(s) ^ bq[i].w;
                e.d = bq[i].w;
            end
            e.c = bq[i].c; e.dn = bq[i].dn; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic build_pkt();
        int c = (g_code > 9) ? 0 : g_code;
        int nw = (g_len + 1) / 2, half = nw / 2;
        logic [7:0] hi, lo; logic [1:0] es;
        bq.delete();
        addw({1'b1, 2'b00, c != 2, g_port, 4'h0}, 1, 0, 0);
        addw({(c == 1 || c == 8), g_len}, 0, 0, 0);
        for (int i = 0; i < nw; i++) begin
            hi = g_seed + 8'(2 * i); lo = hi + 8'd1;
            if (i == nw - 1 && g_len[0]) lo = 8'h00;
            addw({hi, lo}, 0, 0, 0);
            if ((c == 4 || c == 5) && i + 1 == half) begin
                if (c == 5) addw(16'h0000, 1, 0, 0);
                addw({1'b1, 2'b00, 1'b0, g_port, 4'h0}, 1, 0, 0);
            end
        end
        if (c == 3) es = 2'b00;
        else if (c == 7 || c == 8) es = 2'b01;
        else es = g_len[0] ? 2'b11 : 2'b10;
        addw({1'b0, es, (c == 6 || c == 7), 8'h00, 4'h0}, 1, (c == 1 || c == 9), 1);
        finalize(g_tag);
    endtask

    task automatic build_raw();
        bq.delete();
        addw(g_cw, 1, g_inv, 1);
        finalize(g_tag);
    endtask

    // Compare the ports with the model after a clock edge.
    task automatic check_outputs();
        ent_t e;
        if (!live) begin
            n_cmp++;
            if (tx_data !== 0 || tx_ctl !== 0 || tx_valid !== 0 || done !== 0 || busy !== 0) begin
                n_bad++;
                $display("FAIL R1: data=%h ctl=%b valid=%b done=%b busy=%b expected all zero",
                         tx_data, tx_ctl, tx_valid, done, busy);
            end
            return;
        end
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else begin e.d = 16'h000F; e.c = 1; e.dn = 0; e.tag = "R2"; end
        n_cmp++;
        if (tx_data !== e.d || tx_ctl !== e.c || done !== e.dn || tx_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: data=%h ctl=%b done=%b valid=%b expected data=%h ctl=%b done=%b valid=1",
                     e.tag, tx_data, tx_ctl, done, tx_valid, e.d, e.c, e.dn);
        end
        n_cmp++;
        if (busy !== (exp_q.size() > 0)) begin
            n_bad++;
            $display("FAIL R13: busy=%b expected %b", busy, exp_q.size() > 0);
        end
        saw_done = done;
    endtask

    // One clock: check, then drive strobes (optionally only on done).
    task automatic step(input bit ps, input bit cs, input bit on_done);
        bit gp, gc;
        @(negedge clk);
        check_outputs();
        gp = ps && (!on_done || saw_done);
        gc = cs && (!on_done || saw_done);
        pkt_start = gp; cw_start = gc;
        pkt_port = g_port; pkt_err = g_code; pkt_len = g_len; pkt_seed = g_seed;
        cw_word = g_cw; cw_inv = g_inv;
        accepted = 0;
        if (live && exp_q.size() == 0 && (gp || gc)) begin
            accepted = 1;
            if (gp) build_pkt(); else build_raw();
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 40000 && exp_q.size() > 0; k++) step(0, 0, 0);
        step(0, 0, 0);
    endtask

    task automatic set_pkt(input [7:0] port, input [3:0] code, input [14:0] len,
                           input [7:0] seed, input string tag);
        g_port = port; g_code = code; g_len = len; g_seed = seed; g_tag = tag;
    endtask

    task automatic send_pkt(input [7:0] port, input [3:0] code, input [14:0] len,
                            input [7:0] seed, input string tag);
        set_pkt(port, code, len, seed, tag);
        step(1, 0, 0);
        drain();
    endtask

    task automatic send_raw(input [15:0] w, input bit inv, input string tag);
        g_cw = w; g_inv = inv; g_tag = tag;
        step(0, 1, 0);
        drain();
    endtask

    initial begin
        g_cw = '0; g_inv = 0;
        set_pkt(8'h00, 4'd0, 15'd0, 8'h00, "R4");
        // R1: reset state
        repeat (3) step(0, 0, 0);
        @(negedge clk); check_outputs(); rst_n = 1'b1; live = 1;
        // R2: idle fill
        repeat (3) step(0, 0, 0);
        // R4 / R5 / R6: clean packets, odd and even, byte wrap
        send_pkt(8'hA5, 4'd0, 15'd7, 8'hFE, "R4");
        send_pkt(8'h3C, 4'd0, 15'd6, 8'h10, "R5");
        send_pkt(8'h01, 4'd0, 15'd1, 8'h77, "R6");
        send_pkt(8'h02, 4'd0, 15'd0, 8'h00, "R6");
        // R7: parity faults
        send_pkt(8'h11, 4'd1, 15'd5, 8'h20, "R7");
        send_pkt(8'h12, 4'd9, 15'd4, 8'h30, "R7");
        // R8: missing marks
        send_pkt(8'h13, 4'd2, 15'd3, 8'h40, "R8");
        send_pkt(8'h14, 4'd3, 15'd4, 8'h50, "R8");
        // R9: mid-packet control words
        send_pkt(8'h15, 4'd4, 15'd8, 8'h60, "R9");
        send_pkt(8'h16, 4'd5, 15'd9, 8'h70, "R9");
        send_pkt(8'h17, 4'd4, 15'd2, 8'h80, "R9");
        send_pkt(8'h18, 4'd5, 15'd4, 8'h90, "R9");
        // R10: start mark in closing word
        send_pkt(8'h19, 4'd6, 15'd3, 8'hA0, "R10");
        send_pkt(8'h1A, 4'd7, 15'd6, 8'hB0, "R10");
        // R11: abort and undefined codes
        send_pkt(8'h1B, 4'd8, 15'd5, 8'hC0, "R11");
        send_pkt(8'h1C, 4'd12, 15'd3, 8'hD0, "R11");
        send_pkt(8'h1D, 4'd15, 15'd2, 8'hE0, "R11");
        // R12: raw control words
        send_raw(16'h9A5C, 0, "R12");
        send_raw(16'h1234, 1, "R12");
        // R3: both strobes together, packet wins
        set_pkt(8'h21, 4'd0, 15'd4, 8'h05, "R3");
        g_cw = 16'hF0F0; g_inv = 1;
        step(1, 1, 0);
        // R3: strobes while busy are ignored
        step(0, 1, 0);
        step(1, 1, 0);
        drain();
        // R13 / R3: next command strobed in the cycle done is seen
        send_pkt(8'h22, 4'd0, 15'd5, 8'h33, "R13");
        set_pkt(8'h23, 4'd0, 15'd3, 8'h44, "R13");
        step(1, 0, 0);
        set_pkt(8'h24, 4'd6, 15'd2, 8'h55, "R13");
        for (int k = 0; k < 100 && !accepted; k++) step(1, 0, 1);
        step(0, 0, 0);
        g_cw = 16'h8001; g_inv = 0; g_tag = "R13";
        for (int k = 0; k < 100 && !accepted; k++) step(0, 1, 1);
        drain();
        repeat (2) step(0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule